// File: doc/BRIEF.md
# 64-Source Threshold-Gated Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and steers each one to either a fast interrupt line or a normal interrupt line. Every source owns a pending bit, an enable bit, a type bit that selects fast (1) or normal (0), and a 4-bit priority. The fast line is raised whenever any enabled source of fast type is pending. The normal line is further filtered by a 5-bit threshold: it is raised only when some enabled, pending normal source has a priority strictly above the threshold. The threshold value 0x1F switches this filtering off, so that any enabled, pending normal source raises the line.

Software programs the block through a simple 32-bit register bus. The bus has a valid strobe, a write flag, a 10-bit byte address (word offset = address bits 9:2), write data, and registered read data that appears one cycle after the read request. Through this bus software can set or clear single enables by source number, write the enable, type, priority and threshold state, read back the raw, normal-qualified and fast-qualified pending vectors, and overwrite either half of the pending vector. Both interrupt outputs are registered and follow a change of internal state by one clock.

Top module: `intc64_core`

## Requirements
- R1: After reset the threshold reads 0x1F; pending, enable, type, control and every priority read zero; both interrupt outputs are low.
- R2: The fast output is high exactly when some source has pending, enable and type all set (type bit 1 = fast).
- R3: When the threshold is 0x1F, the normal output is high exactly when some source has pending and enable set and type clear.
- R4: When the threshold is below 0x1F, the normal output is high only if an enabled, pending normal source has a priority strictly greater than the threshold; an equal priority does not raise it.
- R5: A write to the threshold register (word offset 1) keeps only data bits 4:0.
- R6: A write to word offset 2 sets, and to word offset 3 clears, the enable bit numbered by data bits 5:0; both offsets read zero.
- R7: Priority words sit at word offsets 8 to 15, offset k holding word 15-k; word w carries sources 8w to 8w+7, source n in bits 4*(n mod 8)+3 down to 4*(n mod 8).
- R8: A write to word offset 21 (low) or 20 (high) replaces that half of the pending vector and wins over a source change in the same cycle; these offsets read zero; writes to the raw pending offsets 19 (low) and 18 (high) are ignored.
- R9: A change of a source input is copied into its pending bit: a rise sets it and a fall clears it; a steady input leaves the bit alone.
- R10: Word offsets 23/22 read the low/high halves of pending AND enable AND NOT type; offsets 25/24 read pending AND enable AND type. Enable halves are at 5/4, type halves at 7/6, control at 0.
- R11: An access to an unmapped word offset (16, 17 and 26 upward) reads zero and changes no state.
- R12: Read data is valid on the clock after the read request; each interrupt output reflects the state one clock after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level-sensitive source inputs |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fast_irq_o | output | 1 | Fast interrupt request |
| norm_irq_o | output | 1 | Threshold-gated normal interrupt request |

## Verification
A corrupted enable, type, priority or threshold bit shows up on the interrupt lines one clock after the corrupting event, but only when a pending source exercises that bit; the reference model in the bench is compared on both lines every clock, so such a fault is caught in the cycle it first matters. Faults that stay latent on the lines (a wrong priority nibble for an idle source, a lost pending bit of a disabled source) are exposed through the read-back registers, which the directed sequence reads right after each change. Boundary cases of the threshold comparison (equal priority, threshold above every priority, the bypass value) are driven explicitly because a single off-by-one there changes the normal line immediately.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int OFF_W = 8;

    typedef enum logic [OFF_W-1:0] {
        OFF_CTRL       = 8'd0,
        OFF_THRESH     = 8'd1,
        OFF_EN_NUM     = 8'd2,
        OFF_DIS_NUM    = 8'd3,
        OFF_EN_HI      = 8'd4,
        OFF_EN_LO      = 8'd5,
        OFF_TYPE_HI    = 8'd6,
        OFF_TYPE_LO    = 8'd7,
        OFF_PRIO_FIRST = 8'd8,
        OFF_PRIO_LAST  = 8'd15,
        OFF_RAW_HI     = 8'd18,
        OFF_RAW_LO     = 8'd19,
        OFF_FORCE_HI   = 8'd20,
        OFF_FORCE_LO   = 8'd21,
        OFF_NPEND_HI   = 8'd22,
        OFF_NPEND_LO   = 8'd23,
        OFF_FPEND_HI   = 8'd24,
        OFF_FPEND_LO   = 8'd25
    } reg_off_e;

endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               force_hi_we_i,
    input  logic               force_lo_we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_SRC-1:0] pend_o
);

    localparam int HALF = NUM_SRC / 2;

    logic [NUM_SRC-1:0] src_d;
    logic [NUM_SRC-1:0] pend_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        localparam bit UPPER = (i >= HALF);
        localparam int WBIT  = i % HALF;

        logic force_we;
        assign force_we = UPPER ? force_hi_we_i : force_lo_we_i;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_d[i]  <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                src_d[i] <= src_i[i];
                if (force_we) begin
                    pend_q[i] <= wdata_i[WBIT];
                end else if (src_i[i] != src_d[i]) begin
                    pend_q[i] <= src_i[i];
                end
            end
        end

        AST_SRC_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (!force_we && src_i[i] && !src_d[i]) |=> pend_q[i]); // R9
        AST_SRC_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (!force_we && !src_i[i] && src_d[i]) |=> !pend_q[i]); // R9
    end

    assign pend_o = pend_q;

    AST_FORCE_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        force_lo_we_i |=> (pend_q[HALF-1:0] == $past(wdata_i[HALF-1:0]))); // R8
    AST_FORCE_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        force_hi_we_i |=> (pend_q[NUM_SRC-1:HALF] == $past(wdata_i[HALF-1:0]))); // R8

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int PRIO_W  = 4,
    parameter int THR_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic                      rd_en_i,
    input  logic [OFF_W-1:0]          word_off_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [NUM_SRC-1:0]        pend_i,
    output logic [NUM_SRC-1:0]        en_o,
    output logic [NUM_SRC-1:0]        type_o,
    output logic [THR_W-1:0]          thr_o,
    output logic [NUM_SRC*PRIO_W-1:0] prio_o,
    output logic                      force_hi_we_o,
    output logic                      force_lo_we_o,
    output logic [DATA_W-1:0]         rdata_o
);

    localparam int HALF       = NUM_SRC / 2;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int PRIO_WORDS = NUM_SRC * PRIO_W / DATA_W;
    localparam int PW_W       = $clog2(PRIO_WORDS);

    logic [DATA_W-1:0]         ctrl_q;
    logic [THR_W-1:0]          thr_q;
    logic [NUM_SRC-1:0]        en_q;
    logic [NUM_SRC-1:0]        type_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0]         rdata_q;
    logic [DATA_W-1:0]         rd_next;
    logic                      mapped;
    logic                      is_prio;
    logic [OFF_W-1:0]          prio_diff;
    logic [PW_W-1:0]           prio_word;
    logic [IDX_W-1:0]          num_sel;
    logic [NUM_SRC-1:0]        norm_pend;
    logic [NUM_SRC-1:0]        fast_pend;

    assign is_prio   = (word_off_i >= OFF_PRIO_FIRST) && (word_off_i <= OFF_PRIO_LAST);
    assign prio_diff = OFF_PRIO_LAST - word_off_i;
    assign prio_word = prio_diff[PW_W-1:0];
    assign num_sel   = wdata_i[IDX_W-1:0];
    assign norm_pend = pend_i & en_q & ~type_q;
    assign fast_pend = pend_i & en_q & type_q;

    assign force_hi_we_o = wr_en_i && (word_off_i == OFF_FORCE_HI);
    assign force_lo_we_o = wr_en_i && (word_off_i == OFF_FORCE_LO);

    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            thr_q  <= '1;
            en_q   <= '0;
            type_q <= '0;
            prio_q <= '0;
        end else if (wr_en_i) begin
            unique case (word_off_i)
                OFF_CTRL:    ctrl_q <= wdata_i;
                OFF_THRESH:  thr_q  <= wdata_i[THR_W-1:0];
                OFF_EN_NUM:  en_q[num_sel] <= 1'b1;
                OFF_DIS_NUM: en_q[num_sel] <= 1'b0;
                OFF_EN_HI:   en_q[NUM_SRC-1:HALF]   <= wdata_i[HALF-1:0];
                OFF_EN_LO:   en_q[HALF-1:0]         <= wdata_i[HALF-1:0];
                OFF_TYPE_HI: type_q[NUM_SRC-1:HALF] <= wdata_i[HALF-1:0];
                OFF_TYPE_LO: type_q[HALF-1:0]       <= wdata_i[HALF-1:0];
                default: begin
                    if (is_prio) begin
                        prio_q[prio_word*DATA_W +: DATA_W] <= wdata_i;
                    end
                end
            endcase
        end
    end

    // Read selection
    always_comb begin
        rd_next = '0;
        mapped  = 1'b1;
        unique case (word_off_i)
            OFF_CTRL:     rd_next = ctrl_q;
            OFF_THRESH:   rd_next = DATA_W'(thr_q);
            OFF_EN_NUM, OFF_DIS_NUM,
            OFF_FORCE_HI, OFF_FORCE_LO: rd_next = '0;
            OFF_EN_HI:    rd_next = en_q[NUM_SRC-1:HALF];
            OFF_EN_LO:    rd_next = en_q[HALF-1:0];
            OFF_TYPE_HI:  rd_next = type_q[NUM_SRC-1:HALF];
            OFF_TYPE_LO:  rd_next = type_q[HALF-1:0];
            OFF_RAW_HI:   rd_next = pend_i[NUM_SRC-1:HALF];
            OFF_RAW_LO:   rd_next = pend_i[HALF-1:0];
            OFF_NPEND_HI: rd_next = norm_pend[NUM_SRC-1:HALF];
            OFF_NPEND_LO: rd_next = norm_pend[HALF-1:0];
            OFF_FPEND_HI: rd_next = fast_pend[NUM_SRC-1:HALF];
            OFF_FPEND_LO: rd_next = fast_pend[HALF-1:0];
            default: begin
                if (is_prio) begin
                    rd_next = prio_q[prio_word*DATA_W +: DATA_W];
                end else begin
                    mapped = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            rdata_q <= rd_next;
        end
    end

    assign en_o    = en_q;
    assign type_o  = type_q;
    assign thr_o   = thr_q;
    assign prio_o  = prio_q;
    assign rdata_o = rdata_q;

    AST_ENNUM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && word_off_i == OFF_EN_NUM) |=> en_q[$past(num_sel)]); // R6
    AST_DISNUM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && word_off_i == OFF_DIS_NUM) |=> !en_q[$past(num_sel)]); // R6
    AST_NUM_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (word_off_i == OFF_EN_NUM || word_off_i == OFF_DIS_NUM)) |=> (rdata_q == '0)); // R6
    AST_THRESH_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && word_off_i == OFF_THRESH) |=> (thr_q == $past(wdata_i[THR_W-1:0]))); // R5
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !mapped) |=> (rdata_q == '0)); // R11
    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !mapped) |=> ($stable(en_q) && $stable(type_q) && $stable(thr_q) && $stable(prio_q))); // R11

endmodule

// File: rtl/intc_gate.sv
module intc_gate #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int THR_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC-1:0]        type_i,
    input  logic [THR_W-1:0]          thr_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output logic                      fast_o,
    output logic                      norm_o
);

    localparam logic [THR_W-1:0] THR_OPEN = '1;
    localparam int               PRIO_MAX = (1 << PRIO_W) - 1;

    logic [NUM_SRC-1:0] norm_vec;
    logic [NUM_SRC-1:0] fast_vec;
    logic [NUM_SRC-1:0] above;
    logic               fast_q;
    logic               norm_q;
    logic               norm_next;

    assign norm_vec = pend_i & en_i & ~type_i;
    assign fast_vec = pend_i & en_i & type_i;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
        logic [THR_W-1:0] prio_ext;
        assign prio_ext = THR_W'(prio_i[i*PRIO_W +: PRIO_W]);
        assign above[i] = norm_vec[i] && (prio_ext > thr_i);
    end

    assign norm_next = (|norm_vec) && ((thr_i == THR_OPEN) || (|above));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            norm_q <= 1'b0;
        end else begin
            fast_q <= |fast_vec;
            norm_q <= norm_next;
        end
    end

    assign fast_o = fast_q;
    assign norm_o = norm_q;

    AST_FAST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_i & type_i) == '0) |=> !fast_o); // R2
    AST_OPEN_THRESH_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_i == THR_OPEN) && (norm_vec != '0)) |=> norm_o); // R3
    AST_HIGH_THRESH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_i >= THR_W'(PRIO_MAX)) && (thr_i != THR_OPEN)) |=> !norm_o); // R4
    AST_NO_NORMAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_vec == '0) |=> !norm_o); // R3

endmodule

// File: rtl/intc64_core.sv
module intc64_core #(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10,
    parameter int PRIO_W  = 4,
    parameter int THR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_valid_i,
    input  logic               bus_write_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               fast_irq_o,
    output logic               norm_irq_o
);

    localparam int OFF_W = intc_pkg::OFF_W;

    logic [OFF_W-1:0]          word_off;
    logic                      wr_en;
    logic                      rd_en;
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC-1:0]        en;
    logic [NUM_SRC-1:0]        typ;
    logic [THR_W-1:0]          thr;
    logic [NUM_SRC*PRIO_W-1:0] prio;
    logic                      force_hi_we;
    logic                      force_lo_we;

    assign word_off = bus_addr_i[ADDR_W-1:2];
    assign wr_en    = bus_valid_i && bus_write_i;
    assign rd_en    = bus_valid_i && !bus_write_i;

    intc_pending #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) i_pending (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_i         (src_i),
        .force_hi_we_i (force_hi_we),
        .force_lo_we_i (force_lo_we),
        .wdata_i       (bus_wdata_i),
        .pend_o        (pend)
    );

    intc_regfile #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .PRIO_W  (PRIO_W),
        .THR_W   (THR_W)
    ) i_regfile (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .rd_en_i       (rd_en),
        .word_off_i    (word_off),
        .wdata_i       (bus_wdata_i),
        .pend_i        (pend),
        .en_o          (en),
        .type_o        (typ),
        .thr_o         (thr),
        .prio_o        (prio),
        .force_hi_we_o (force_hi_we),
        .force_lo_we_o (force_lo_we),
        .rdata_o       (bus_rdata_o)
    );

    intc_gate #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .THR_W   (THR_W)
    ) i_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .en_i   (en),
        .type_i (typ),
        .thr_i  (thr),
        .prio_i (prio),
        .fast_o (fast_irq_o),
        .norm_o (norm_irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!fast_irq_o && !norm_irq_o)); // R1

endmodule

// File: tb/test_intc64_core.sv
module test_intc64_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        valid = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fast_irq;
    logic        norm_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intc64_core i_intc64_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_valid_i (valid),
        .bus_write_i (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .fast_irq_o  (fast_irq),
        .norm_irq_o  (norm_irq)
    );

    // Behavioural reference model
    logic [63:0] m_pend, m_en, m_type, m_srcd;
    logic [31:0] m_ctrl;
    int          m_thr;
    int          m_prio [64];
    logic        exp_fast, exp_norm;
    logic [31:0] exp_rd;
    bit          rd_chk;

    function automatic logic [31:0] m_read(int off);
        logic [63:0] np, fp;
        logic [31:0] w;
        np = m_pend & m_en & ~m_type;
        fp = m_pend & m_en & m_type;
        case (off)
            0: return m_ctrl;
            1: return 32'(m_thr);
            4: return m_en[63:32];
            5: return m_en[31:0];
            6: return m_type[63:32];
            7: return m_type[31:0];
            18: return m_pend[63:32];
            19: return m_pend[31:0];
            22: return np[63:32];
            23: return np[31:0];
            24: return fp[63:32];
            25: return fp[31:0];
            default: begin
                if (off >= 8 && off <= 15) begin
                    w = '0;
                    for (int k = 0; k < 8; k++) w[4*k +: 4] = 4'(m_prio[(15 - off) * 8 + k]);
                    return w;
                end
                return '0;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_type = '0; m_srcd = '0; m_ctrl = '0;
            m_thr = 31; exp_fast = 0; exp_norm = 0; rd_chk = 0;
            for (int i = 0; i < 64; i++) m_prio[i] = 0;
        end else begin
            logic [63:0] nv;
            bit hit;
            int off;
            nv = m_pend & m_en & ~m_type;
            exp_fast = |(m_pend & m_en & m_type);
            hit = 0;
            for (int i = 0; i < 64; i++) if (nv[i] && m_prio[i] > m_thr) hit = 1;
            exp_norm = (nv != 0) && (m_thr == 31 || hit);
            off = int'(addr[9:2]);
            rd_chk = valid && !we;
            if (rd_chk) exp_rd = m_read(off);
            for (int i = 0; i < 64; i++) if (src[i] != m_srcd[i]) m_pend[i] = src[i];
            m_srcd = src;
            if (valid && we) begin
                case (off)
                    0: m_ctrl = wdata;
                    1: m_thr = int'(wdata[4:0]);
                    2: m_en[wdata[5:0]] = 1'b1;
                    3: m_en[wdata[5:0]] = 1'b0;
                    4: m_en[63:32] = wdata;
                    5: m_en[31:0] = wdata;
                    6: m_type[63:32] = wdata;
                    7: m_type[31:0] = wdata;
                    20: m_pend[63:32] = wdata;
                    21: m_pend[31:0] = wdata;
                    default: if (off >= 8 && off <= 15)
                        for (int k = 0; k < 8; k++) m_prio[(15 - off) * 8 + k] = int'(wdata[4*k +: 4]);
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model (R2, R3, R4, R12)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 fast line vs model", 32'(fast_irq), 32'(exp_fast));
            chk("R4 normal line vs model", 32'(norm_irq), 32'(exp_norm));
            if (rd_chk) chk("R12 read data vs model", rdata, exp_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic bus_wr(input int off, input logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; we = 1'b1; addr = 10'(off << 2); wdata = d;
        @(negedge clk);
        valid = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input int off, output logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; we = 1'b0; addr = 10'(off << 2);
        @(negedge clk);
        valid = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        chk("R1 fast low", 32'(fast_irq), 0);
        chk("R1 normal low", 32'(norm_irq), 0);
        bus_rd(1, d);  chk("R1 threshold reset", d, 32'h1F);
        bus_rd(0, d);  chk("R1 control reset", d, 0);
        bus_rd(4, d);  chk("R1 enable high reset", d, 0);
        bus_rd(8, d);  chk("R1 priority word reset", d, 0);

        // R9: rising source sets pending
        src[3] = 1'b1;
        idle(3);
        bus_rd(19, d); chk("R9 rise sets pending", d, 32'h8);
        chk("R3 disabled source quiet", 32'(norm_irq), 0);

        // R6 / R12 / R3: enable by number, low 6 bits
        bus_wr(2, 32'h43);
        chk("R12 output not yet updated", 32'(norm_irq), 0);
        idle(1);
        chk("R3 open threshold raises normal", 32'(norm_irq), 1);
        bus_rd(5, d);  chk("R6 enable-by-number bit 3", d, 32'h8);
        bus_rd(2, d);  chk("R6 enable-number reads zero", d, 0);
        bus_rd(3, d);  chk("R6 disable-number reads zero", d, 0);

        // R5 / R4: threshold and strict comparison
        bus_wr(1, 32'h25);
        bus_rd(1, d);  chk("R5 threshold keeps 5 bits", d, 32'h5);
        chk("R4 priority 0 below threshold", 32'(norm_irq), 0);
        bus_wr(15, 32'h0000_5000);
        idle(2);
        chk("R4 equal priority blocked", 32'(norm_irq), 0);
        bus_wr(15, 32'h0000_6000);
        idle(2);
        chk("R4 higher priority passes", 32'(norm_irq), 1);
        bus_rd(15, d); chk("R7 offset 15 is word 0", d, 32'h0000_6000);

        // R2 / R10: fast source 60
        bus_wr(6, 32'h1000_0000);
        src[60] = 1'b1;
        bus_wr(4, 32'h1000_0000);
        idle(2);
        chk("R2 fast line raised", 32'(fast_irq), 1);
        bus_rd(24, d); chk("R10 fast pending high", d, 32'h1000_0000);
        bus_rd(23, d); chk("R10 normal pending low", d, 32'h8);
        bus_rd(22, d); chk("R10 normal pending high", d, 0);

        // R7: offset 8 holds sources 56..63
        bus_wr(6, 32'h0);
        bus_wr(3, 32'h3);
        idle(2);
        chk("R2 fast drops with type cleared", 32'(fast_irq), 0);
        chk("R4 source 60 priority 0 blocked", 32'(norm_irq), 0);
        bus_wr(8, 32'h0007_0000);
        idle(2);
        chk("R7 source 60 nibble raises normal", 32'(norm_irq), 1);
        bus_rd(8, d);  chk("R7 offset 8 readback", d, 32'h0007_0000);
        bus_wr(8, 32'h0003_0000);
        idle(2);
        chk("R7 lower nibble value blocks", 32'(norm_irq), 0);

        // R8: forcing pending
        bus_wr(21, 32'hA5);
        bus_rd(19, d); chk("R8 force replaces low half", d, 32'hA5);
        bus_rd(21, d); chk("R8 force reads zero", d, 0);
        bus_wr(19, 32'h0);
        bus_rd(19, d); chk("R8 raw pending ignores write", d, 32'hA5);

        // R9: rise then fall
        src[1] = 1'b1;
        idle(2);
        bus_rd(19, d); chk("R9 rise on source 1", d, 32'hA7);
        src[1] = 1'b0;
        idle(2);
        bus_rd(19, d); chk("R9 fall on source 1", d, 32'hA5);

        // R11: unmapped offsets
        bus_wr(30, 32'hFFFF_FFFF);
        bus_wr(16, 32'hFFFF_FFFF);
        bus_rd(30, d); chk("R11 unmapped reads zero", d, 0);
        bus_rd(17, d); chk("R11 offset 17 reads zero", d, 0);
        bus_rd(1, d);  chk("R11 threshold untouched", d, 32'h5);
        bus_rd(5, d);  chk("R11 enable untouched", d, 32'h0);

        // R3: reopen threshold
        bus_wr(1, 32'h1F);
        idle(2);
        chk("R3 bypass value passes priority 3", 32'(norm_irq), 1);

        idle(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule